// File: doc/BRIEF.md
# Cascaded Edge-Triggered Interrupt Controller

This block merges sixteen interrupt request lines into a single interrupt output to a processor. The lines are split between two eight-line units. Lines 0 to 7 belong to the primary unit and lines 8 to 15 to the secondary unit. The secondary unit's combined request drives primary line 2, so all secondary lines share the priority of that slot. Each unit captures a request when its input rises. Priority is fixed, and lines already in service block the lines below them.

The processor answers the interrupt with a one-cycle acknowledge strobe. At that edge the controller scans the current input levels. It reports the highest-priority line that is pending, unmasked, unblocked and still high. The line number appears one cycle later with a valid strobe. If the request has disappeared by then, the controller returns a spurious code instead of a real source. The code is 7 when the primary unit finds nothing. It is 15 when the primary unit chose the secondary slot but the secondary unit then finds nothing. An end-of-interrupt strobe retires the highest-priority line in service. Two write-only mask registers hide lines from the output and from the scan, but masked lines still record their edges.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset, intr_o and vec_valid_o are low, no line is pending or in service, and both masks are clear.
- R2: When a line's input is sampled high at a clock edge after being sampled low at the previous edge, that line becomes pending. intr_o is then high right after that edge if the line is unmasked and not blocked. This includes a line that is idle low and then released high by a pull-up.
- R3: An input held high produces no further request. After its request is acknowledged, a new interrupt from the same line needs the input to go low and rise again.
- R4: The acknowledge scan is sampled at the clock edge where ack_i is high. vec_valid_o is high for exactly the next cycle, and vec_o carries the highest-priority line that is pending, unmasked, unblocked and whose input is high at that edge, with spur_o low. Priority runs from line 0 down to line 7, and lines 8 (highest) to 15 (lowest) take primary line 2's place.
- R5: When no primary line qualifies at the scan, vec_o is 7 with spur_o high and nothing enters service. This includes an acknowledge given while intr_o is low.
- R6: When the secondary slot wins the primary scan but no secondary line is still high, vec_o is 15 with spur_o high and nothing enters service.
- R7: A genuine acknowledge puts the reported line in service and clears its pending state. intr_o then drops unless a higher-priority request is eligible.
- R8: While a line is in service, lines of equal or lower priority in the same unit do not raise intr_o. All secondary lines count as primary line 2 for this rule.
- R9: eoi_i retires the highest-priority line in service. Retiring the last secondary line also frees primary line 2.
- R10: mask_we_i writes mask_data_i into the secondary mask when mask_sel_i is 1 and into the primary mask otherwise. A set mask bit keeps its line from raising intr_o and from winning the scan. The line's edge is still recorded, so clearing the bit later raises intr_o.
- R11: Every acknowledge discards the pending state of each line whose input is low at that edge.
- R12: req_i[2] has no effect, because primary line 2 is fed only by the secondary unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 16 | Request lines; bits 0-7 primary, 8-15 secondary, bit 2 unused |
| mask_we_i | input | 1 | Mask write strobe |
| mask_sel_i | input | 1 | Mask select: 1 secondary, 0 primary |
| mask_data_i | input | 8 | Mask value, bit set hides the line |
| ack_i | input | 1 | Acknowledge strobe from the processor |
| eoi_i | input | 1 | End-of-interrupt strobe |
| intr_o | output | 1 | Interrupt request to the processor |
| vec_valid_o | output | 1 | vec_o and spur_o valid, one cycle after ack_i |
| vec_o | output | 4 | Reported line number 0-15 |
| spur_o | output | 1 | Reported number is a spurious code |

## Verification
The hardest case to reach is the spurious code 15. It needs a secondary request that is still pending, so that the primary unit selects its cascade slot. The same request must have gone low at the acknowledge edge, so that the secondary scan comes up empty. The stimulus raises a secondary line, lowers it again before acknowledging, and then checks that the pending state is discarded. Nested service is reached in a similar way. A higher line is raised while a lower one is in service, and a third line is held blocked so that each end-of-interrupt shows which in-service bit it retired.

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl #(
  parameter int CASC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] req_i,
  input  logic        mask_we_i,
  input  logic        mask_sel_i,
  input  logic [7:0]  mask_data_i,
  input  logic        ack_i,
  input  logic        eoi_i,
  output logic        intr_o,
  output logic        vec_valid_o,
  output logic [3:0]  vec_o,
  output logic        spur_o
);
  localparam int N = 8;
  localparam logic [3:0]    SPUR_P   = 4'(N - 1);
  localparam logic [3:0]    SPUR_S   = 4'(2 * N - 1);
  localparam logic [2*N-1:0] CASC_BIT = (2*N)'(1) << CASC;

  function automatic logic [N-1:0] at_or_above(input logic [N-1:0] v);
    logic [N-1:0] r;
    r[0] = v[0];
    for (int j = 1; j < N; j++) r[j] = r[j-1] | v[j];
    return r;
  endfunction

  function automatic logic [N-1:0] lowest(input logic [N-1:0] v);
    return v & (~v + N'(1));
  endfunction

  function automatic logic [2:0] enc(input logic [N-1:0] v);
    logic [2:0] r;
    r = '0;
    for (int j = 0; j < N; j++) if (v[j]) r = 3'(j);
    return r;
  endfunction

  logic [2*N-1:0] lvl, irr, isr, rise, keep;
  logic [N-1:0]   mask_p, mask_s;
  logic [N-1:0]   elig_s, elig_p, cand_p, scan_p, pick_p, pick_s;
  logic [N-1:0]   set_p, set_s, clr_p, clr_s, top_p, top_s;
  logic           sec_int, casc_hit, sec_found;

  assign elig_s  = irr[2*N-1:N] & ~mask_s & ~at_or_above(isr[2*N-1:N]);
  assign sec_int = |elig_s;

  always_comb begin
    cand_p       = irr[N-1:0];
    cand_p[CASC] = sec_int;
    scan_p       = req_i[N-1:0];
    scan_p[CASC] = 1'b1;
  end

  assign elig_p = cand_p & ~mask_p & ~at_or_above(isr[N-1:0]);
  assign intr_o = |elig_p;

  assign pick_p    = lowest(elig_p & scan_p);
  assign pick_s    = lowest(elig_s & req_i[2*N-1:N]);
  assign casc_hit  = pick_p[CASC];
  assign sec_found = |pick_s;

  assign set_p = (ack_i && (!casc_hit || sec_found)) ? pick_p : '0;
  assign set_s = (ack_i && casc_hit) ? pick_s : '0;

  assign top_p = lowest(isr[N-1:0]);
  assign top_s = lowest(isr[2*N-1:N]);

  always_comb begin
    clr_p = '0;
    clr_s = '0;
    if (eoi_i) begin
      if (top_p[CASC]) begin
        clr_s = top_s;
        if ((isr[2*N-1:N] & ~top_s) == '0) clr_p = top_p;
      end else begin
        clr_p = top_p;
      end
    end
  end

  assign rise = req_i & ~lvl & ~CASC_BIT;
  assign keep = ack_i ? req_i : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl         <= '0;
      irr         <= '0;
      isr         <= '0;
      mask_p      <= '0;
      mask_s      <= '0;
      vec_valid_o <= 1'b0;
      vec_o       <= '0;
      spur_o      <= 1'b0;
    end else begin
      lvl <= req_i;
      irr <= (irr & keep & ~{set_s, set_p}) | rise;
      isr <= (isr & ~{clr_s, clr_p}) | {set_s, set_p};
      if (mask_we_i) begin
        if (mask_sel_i) mask_s <= mask_data_i;
        else            mask_p <= mask_data_i;
      end
      vec_valid_o <= ack_i;
      if (ack_i) begin
        if (pick_p == '0) begin
          vec_o  <= SPUR_P;
          spur_o <= 1'b1;
        end else if (casc_hit && !sec_found) begin
          vec_o  <= SPUR_S;
          spur_o <= 1'b1;
        end else if (casc_hit) begin
          vec_o  <= {1'b1, enc(pick_s)};
          spur_o <= 1'b0;
        end else begin
          vec_o  <= {1'b0, enc(pick_p)};
          spur_o <= 1'b0;
        end
      end
    end
  end

  a_r4_valid_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> vec_valid_o);
  a_r4_no_valid_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> !vec_valid_o);
  a_r5_spur_codes_only: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && spur_o) |-> (vec_o == SPUR_P || vec_o == SPUR_S));
  a_r7_genuine_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && !spur_o) |-> isr[vec_o]);
  a_r9_cascade_tracks_secondary: assert property (@(posedge clk) disable iff (!rst_n)
    isr[CASC] == (|isr[2*N-1:N]));
  a_r12_no_cascade_pending: assert property (@(posedge clk) disable iff (!rst_n)
    !irr[CASC]);
  a_r2_intr_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    intr_o |-> (|(irr & ~{mask_s, mask_p})));
  a_r3_no_pend_while_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((irr & ~$past(irr)) & $past(lvl)) == '0);
endmodule

// File: tb/cascade_irq_ctrl_tb.sv
`timescale 1ns/1ps
module cascade_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] req_i = '0;
  logic        mask_we_i = 1'b0, mask_sel_i = 1'b0;
  logic [7:0]  mask_data_i = '0;
  logic        ack_i = 1'b0, eoi_i = 1'b0;
  logic        intr_o, vec_valid_o, spur_o;
  logic [3:0]  vec_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cascade_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i),
    .mask_we_i(mask_we_i), .mask_sel_i(mask_sel_i), .mask_data_i(mask_data_i),
    .ack_i(ack_i), .eoi_i(eoi_i),
    .intr_o(intr_o), .vec_valid_o(vec_valid_o), .vec_o(vec_o), .spur_o(spur_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit pend[16], ins[16], lastv[16], mk[16];
  bit m_vv, m_spur;
  int m_vec;

  function automatic bit s_ok(int j);
    if (!pend[8+j] || mk[8+j]) return 0;
    for (int k = 0; k <= j; k++) if (ins[8+k]) return 0;
    return 1;
  endfunction

  function automatic bit s_any();
    for (int j = 0; j < 8; j++) if (s_ok(j)) return 1;
    return 0;
  endfunction

  function automatic bit p_ok(int j);
    if (mk[j]) return 0;
    for (int k = 0; k <= j; k++) if (ins[k]) return 0;
    if (j == 2) return s_any();
    return pend[j];
  endfunction

  function automatic bit m_intr();
    for (int j = 0; j < 8; j++) if (p_ok(j)) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    int code, ce, cs, left;
    bit sp;
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin
        pend[i] = 0; ins[i] = 0; lastv[i] = 0; mk[i] = 0;
      end
      m_vv = 0; m_spur = 0; m_vec = 0;
    end else begin
      code = 7; sp = 1; ce = -1; cs = -1;
      if (ack_i) begin
        for (int j = 0; j < 8; j++) begin
          if (p_ok(j) && (j == 2 || req_i[j])) begin
            if (j == 2) begin
              code = 15;
              for (int k = 0; k < 8; k++)
                if (s_ok(k) && req_i[8+k]) begin code = 8 + k; sp = 0; break; end
            end else begin
              code = j; sp = 0;
            end
            break;
          end
        end
      end
      if (eoi_i) begin
        for (int j = 0; j < 8; j++) begin
          if (ins[j]) begin
            if (j == 2) begin
              left = 0;
              for (int k = 0; k < 8; k++)
                if (ins[8+k]) begin
                  if (cs < 0) cs = 8 + k; else left++;
                end
              if (left == 0) ce = 2;
            end else ce = j;
            break;
          end
        end
      end
      if (ce >= 0) ins[ce] = 0;
      if (cs >= 0) ins[cs] = 0;
      if (ack_i) begin
        for (int i = 0; i < 16; i++) if (!req_i[i]) pend[i] = 0;
        if (!sp) begin
          pend[code] = 0; ins[code] = 1;
          if (code >= 8) ins[2] = 1;
        end
        m_vec = code; m_spur = sp;
      end
      m_vv = ack_i;
      if (mask_we_i)
        for (int i = 0; i < 8; i++) mk[(mask_sel_i ? 8 : 0) + i] = mask_data_i[i];
      for (int i = 0; i < 16; i++) begin
        if (i != 2 && req_i[i] && !lastv[i]) pend[i] = 1;
        lastv[i] = req_i[i];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 model intr_o", intr_o, m_intr());
      chk("R4 model vec_valid_o", vec_valid_o, m_vv);
      if (m_vv) begin
        chk("R4 model vec_o", vec_o, m_vec);
        chk("R5 model spur_o", spur_o, m_spur);
      end
    end
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic line(int i, bit v); req_i[i] = v; tick(); endtask
  task automatic do_ack(); ack_i = 1; tick(); ack_i = 0; endtask
  task automatic do_eoi(); eoi_i = 1; tick(); eoi_i = 0; endtask
  task automatic wmask(bit sel, logic [7:0] d);
    mask_we_i = 1; mask_sel_i = sel; mask_data_i = d; tick(); mask_we_i = 0;
  endtask
  task automatic exp_vec(string tag, int v, bit s);
    chk({tag, " valid"}, vec_valid_o, 1);
    chk({tag, " number"}, vec_o, v);
    chk({tag, " spurious"}, spur_o, s);
  endtask

  initial begin
    repeat (3) tick();
    chk("R1 intr_o in reset", intr_o, 0);
    chk("R1 vec_valid_o in reset", vec_valid_o, 0);
    rst_n = 1; tick();
    chk("R1 intr_o after reset", intr_o, 0);

    line(5, 1);
    chk("R2 rise raises intr_o", intr_o, 1);
    do_ack();
    exp_vec("R4 single line 5", 5, 0);
    chk("R7 intr_o drops after ack", intr_o, 0);
    tick();
    chk("R4 valid lasts one cycle", vec_valid_o, 0);
    do_eoi();
    tick();
    chk("R3 held line gives no new request", intr_o, 0);
    line(5, 0);
    line(5, 1);
    chk("R3 re-rise raises intr_o", intr_o, 1);
    do_ack(); exp_vec("R3 re-rise vector", 5, 0);
    do_eoi(); line(5, 0);

    req_i[6] = 1; req_i[3] = 1; tick();
    do_ack(); exp_vec("R4 priority 3 over 6", 3, 0);
    chk("R8 line 6 blocked by 3", intr_o, 0);
    do_eoi();
    chk("R8 line 6 released after eoi", intr_o, 1);
    do_ack(); exp_vec("R4 line 6 after eoi", 6, 0);
    do_eoi(); req_i = '0; tick();

    req_i[0] = 1; req_i[5] = 1; tick();
    line(0, 0);
    do_ack(); exp_vec("R4 vanished line 0 skipped", 5, 0);
    chk("R11 vanished line 0 discarded", intr_o, 0);
    do_eoi(); req_i = '0; tick();

    line(4, 1); line(4, 0);
    chk("R5 pending after drop", intr_o, 1);
    do_ack(); exp_vec("R5 vanished primary", 7, 1);
    chk("R11 discarded after spurious", intr_o, 0);
    do_ack(); exp_vec("R5 ack with intr low", 7, 1);

    line(10, 1); line(10, 0);
    chk("R6 secondary pending", intr_o, 1);
    do_ack(); exp_vec("R6 vanished secondary", 15, 1);
    chk("R11 secondary discarded", intr_o, 0);

    line(9, 1);
    do_ack(); exp_vec("R4 secondary line 9", 9, 0);
    line(1, 1);
    chk("R8 line 1 nests over cascade", intr_o, 1);
    do_ack(); exp_vec("R4 nested line 1", 1, 0);
    do_eoi();
    line(12, 1);
    chk("R8 line 12 blocked by line 9", intr_o, 0);
    do_eoi();
    chk("R9 eoi frees cascade", intr_o, 1);
    do_ack(); exp_vec("R9 line 12 served", 12, 0);
    do_eoi(); req_i = '0; tick();

    line(3, 1); do_ack(); exp_vec("R9 setup line 3", 3, 0);
    line(1, 1); do_ack(); exp_vec("R9 setup line 1", 1, 0);
    line(4, 1);
    chk("R8 line 4 blocked", intr_o, 0);
    do_eoi();
    chk("R9 first eoi retires line 1 only", intr_o, 0);
    do_eoi();
    chk("R9 second eoi retires line 3", intr_o, 1);
    do_ack(); exp_vec("R9 line 4 served", 4, 0);
    do_eoi(); req_i = '0; tick();

    wmask(0, 8'h40);
    line(6, 1);
    chk("R10 masked line 6 silent", intr_o, 0);
    do_ack(); exp_vec("R10 masked line not scanned", 7, 1);
    wmask(0, 8'h00);
    chk("R10 unmask shows recorded edge", intr_o, 1);
    do_ack(); exp_vec("R10 line 6 after unmask", 6, 0);
    do_eoi(); req_i = '0; tick();

    wmask(1, 8'h08);
    line(11, 1);
    chk("R10 masked secondary silent", intr_o, 0);
    do_ack(); exp_vec("R10 masked secondary not scanned", 7, 1);
    wmask(1, 8'h00);
    chk("R10 secondary unmask", intr_o, 1);
    do_ack(); exp_vec("R10 line 11 after unmask", 11, 0);
    do_eoi(); req_i = '0; tick();

    line(2, 1);
    chk("R12 line 2 input ignored", intr_o, 0);
    do_ack(); exp_vec("R12 line 2 not reported", 7, 1);
    line(2, 0);

    line(7, 0); line(7, 1);
    chk("R2 released pull-up edge", intr_o, 1);
    do_ack(); exp_vec("R2 line 7 genuine", 7, 0);
    do_eoi(); req_i = '0;
    repeat (3) tick();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule